// File: doc/BRIEF.md
# Erase Range Block Walker

The walker takes one erase request, a start offset and a length, over a flash space divided into up to `NREG` regions. Each region has a base offset, a power-of-two block size and a block count. The flash space is spread over several chips, each `2^chip_lg2_i` bytes in size. The walker first finds the region that holds the start offset and checks that the start is a multiple of that region's block size. It then finds the region that holds the end offset (start plus length) and checks that the end is a multiple of that region's block size. Only when both checks pass does it begin the walk.

During the walk, the walker issues one block request at a time to an outside block handler. Each request carries a chip number, an address inside that chip and a byte size. The walker waits for the handler's completion pulse and status. It moves on to the next region at each region end, and to the next chip when the in-chip address passes the chip size. At the end it pulses `done_o` and reports either an alignment rejection or the handler's status.

Top module: `erase_walker`

## Requirements
- R1: The start region is found by stepping forward through the table while the start offset is at or above the region base, then stepping back one region. If no region base is at or below the start, the request ends with `bad_align_o`=1 and issues no block request.
- R2: A start offset that is not a multiple of its region's block size ends the request with `bad_align_o`=1, `fail_code_o`=0 and no block request.
- R3: The end offset (start plus length) is located the same way, with the scan beginning at the start region. If the end is not a multiple of its region's block size, the request ends with `bad_align_o`=1 and issues no block request.
- R4: The first request carries chip number `ofs >> chip_lg2_i` and in-chip address `ofs` minus that chip number shifted left by `chip_lg2_i`. Every request address lies below `2^chip_lg2_i` and is a multiple of its size.
- R5: Block requests are issued one at a time, in ascending offset order. Each request uses the current region's block size, and `blk_req_o`, `blk_chip_o`, `blk_addr_o` and `blk_size_o` stay unchanged until `blk_done_i` is seen.
- R6: A nonzero `blk_status_i` stops the walk at once. `done_o` pulses in the next cycle, and `fail_code_o` carries that status.
- R7: When the offset reaches region base plus block size times block count, the following requests use the next region's block size.
- R8: When the in-chip address overflows `chip_lg2_i` bits, it restarts at 0 and the chip number goes up by one. If the new chip number is at or above `chip_num_i`, the walk ends with success.
- R9: A start with zero length pulses `done_o` in the cycle after `start_i`, with success and no block request.
- R10: A walk that uses up its whole length ends with `done_o`, `bad_align_o`=0 and `fail_code_o`=0, and `busy_o` is low while `done_o` is high.
- R11: `start_i` is ignored while `busy_o` is high. The request sequence and the result of the walk in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| ofs_i | input | ADDR_W | Start offset of the request |
| len_i | input | ADDR_W | Length of the request in bytes |
| rgn_base_i | input | NREG*ADDR_W | Region base offsets, region k in slice k |
| rgn_lg2_i | input | NREG*SH_W | Region block size as log2, region k in slice k |
| rgn_cnt_i | input | NREG*ADDR_W | Region block counts, region k in slice k |
| rgn_num_i | input | IDX_W | Number of valid regions |
| chip_lg2_i | input | SH_W | Chip size as log2 |
| chip_num_i | input | CHIP_W+1 | Number of chips |
| blk_req_o | output | 1 | Block request valid |
| blk_chip_o | output | CHIP_W | Chip number of the request |
| blk_addr_o | output | ADDR_W | Address inside the chip |
| blk_size_o | output | ADDR_W | Block size in bytes |
| blk_done_i | input | 1 | Handler completion pulse |
| blk_status_i | input | STAT_W | Handler status, 0 means success |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bad_align_o | output | 1 | Last request rejected for alignment |
| fail_code_o | output | STAT_W | Handler status that stopped the last walk |

## Verification
The bench builds the walker with `ADDR_W`=24, four regions, `CHIP_W`=4 and an 8-bit status. The region table mixes 8 KiB, 64 KiB and 32 KiB blocks across 1 MiB, and the chips are 512 KiB each. With these values a single request can cross from small blocks into large ones, and back into small ones. It can also pass a chip boundary, or stop early at the chip limit when the chip count is set to one. A shifted table, whose first base is above zero, makes it possible to reach the case where no region lies below the start offset.

// File: rtl/erase_walker.sv
module erase_walker #(
  parameter int ADDR_W = 24,
  parameter int NREG   = 4,
  parameter int CHIP_W = 4,
  parameter int STAT_W = 8,
  localparam int SH_W  = $clog2(ADDR_W),
  localparam int IDX_W = $clog2(NREG + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      ofs_i,
  input  logic [ADDR_W-1:0]      len_i,
  input  logic [NREG*ADDR_W-1:0] rgn_base_i,
  input  logic [NREG*SH_W-1:0]   rgn_lg2_i,
  input  logic [NREG*ADDR_W-1:0] rgn_cnt_i,
  input  logic [IDX_W-1:0]       rgn_num_i,
  input  logic [SH_W-1:0]        chip_lg2_i,
  input  logic [CHIP_W:0]        chip_num_i,
  output logic                   blk_req_o,
  output logic [CHIP_W-1:0]      blk_chip_o,
  output logic [ADDR_W-1:0]      blk_addr_o,
  output logic [ADDR_W-1:0]      blk_size_o,
  input  logic                   blk_done_i,
  input  logic [STAT_W-1:0]      blk_status_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   bad_align_o,
  output logic [STAT_W-1:0]      fail_code_o
);

  typedef enum logic [2:0] {S_IDLE, S_SCAN_A, S_CHK_A, S_SCAN_B, S_CHK_B, S_WALK} st_t;

  st_t                st;
  logic [ADDR_W-1:0]  ofs_q, len_q, addr_q;
  logic [CHIP_W-1:0]  chip_q;
  logic [IDX_W-1:0]   idx_q, cur_q;
  logic               done_q, bad_q;
  logic [STAT_W-1:0]  code_q;

  logic [ADDR_W-1:0]  base_a [NREG];
  logic [ADDR_W-1:0]  cnt_a  [NREG];
  logic [SH_W-1:0]    lg2_a  [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign base_a[g] = rgn_base_i[g*ADDR_W +: ADDR_W];
    assign cnt_a[g]  = rgn_cnt_i[g*ADDR_W +: ADDR_W];
    assign lg2_a[g]  = rgn_lg2_i[g*SH_W +: SH_W];
  end

  logic [ADDR_W-1:0] idx_base, cur_base, cur_cnt;
  logic [SH_W-1:0]   idx_lg2, cur_lg2;

  always_comb begin
    idx_base = '0;
    idx_lg2  = '0;
    cur_base = '0;
    cur_cnt  = '0;
    cur_lg2  = '0;
    for (int k = 0; k < NREG; k++) begin
      if (idx_q == IDX_W'(k)) begin
        idx_base = base_a[k];
        idx_lg2  = lg2_a[k];
      end
      if (cur_q == IDX_W'(k)) begin
        cur_base = base_a[k];
        cur_cnt  = cnt_a[k];
        cur_lg2  = lg2_a[k];
      end
    end
  end

  logic [ADDR_W-1:0] end_ofs, target, idx_mask, cur_size, rgn_end;
  logic [ADDR_W-1:0] nxt_addr, nxt_ofs, nxt_len, chip_mask;
  logic              scan_go, chip_over, last_chip, last_rgn;

  assign end_ofs   = ofs_q + len_q;
  assign target    = (st == S_SCAN_A) ? ofs_q : end_ofs;
  assign scan_go   = (idx_q < rgn_num_i) && (target >= idx_base);
  assign idx_mask  = (ADDR_W'(1) << idx_lg2) - ADDR_W'(1);
  assign cur_size  = ADDR_W'(1) << cur_lg2;
  assign rgn_end   = cur_base + (cur_cnt << cur_lg2);
  assign nxt_addr  = addr_q + cur_size;
  assign nxt_ofs   = ofs_q + cur_size;
  assign nxt_len   = len_q - cur_size;
  assign chip_mask = (ADDR_W'(1) << chip_lg2_i) - ADDR_W'(1);
  assign chip_over = (nxt_addr >> chip_lg2_i) != '0;
  assign last_chip = ({1'b0, chip_q} + (CHIP_W+1)'(1)) >= chip_num_i;
  assign last_rgn  = cur_q >= (rgn_num_i - IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ofs_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
      chip_q <= '0;
      idx_q  <= '0;
      cur_q  <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          bad_q  <= 1'b0;
          code_q <= '0;
          ofs_q  <= ofs_i;
          len_q  <= len_i;
          idx_q  <= '0;
          if (len_i == '0) done_q <= 1'b1;
          else             st     <= S_SCAN_A;
        end
        S_SCAN_A, S_SCAN_B: begin
          if (scan_go) begin
            idx_q <= idx_q + IDX_W'(1);
          end else if (idx_q == '0) begin
            bad_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            idx_q <= idx_q - IDX_W'(1);
            st    <= (st == S_SCAN_A) ? S_CHK_A : S_CHK_B;
          end
        end
        S_CHK_A: begin
          if ((ofs_q & idx_mask) != '0) begin
            bad_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cur_q <= idx_q;
            st    <= S_SCAN_B;
          end
        end
        S_CHK_B: begin
          if ((end_ofs & idx_mask) != '0) begin
            bad_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            chip_q <= CHIP_W'(ofs_q >> chip_lg2_i);
            addr_q <= ofs_q & chip_mask;
            st     <= S_WALK;
          end
        end
        S_WALK: if (blk_done_i) begin
          if (blk_status_i != '0) begin
            code_q <= blk_status_i;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            addr_q <= nxt_addr;
            ofs_q  <= nxt_ofs;
            len_q  <= nxt_len;
            if (nxt_ofs == rgn_end && !last_rgn) cur_q <= cur_q + IDX_W'(1);
            if (chip_over) begin
              addr_q <= '0;
              chip_q <= chip_q + CHIP_W'(1);
            end
            if ((chip_over && last_chip) || nxt_len == '0) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign blk_req_o   = (st == S_WALK);
  assign blk_chip_o  = chip_q;
  assign blk_addr_o  = addr_q;
  assign blk_size_o  = cur_size;
  assign busy_o      = (st != S_IDLE);
  assign done_o      = done_q;
  assign bad_align_o = bad_q;
  assign fail_code_o = code_q;

endmodule

// File: rtl/erase_walker_chk.sv
module erase_walker_chk #(
  parameter int ADDR_W = 24,
  parameter int CHIP_W = 4,
  parameter int STAT_W = 8,
  parameter int SH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] len_i,
  input logic [SH_W-1:0]   chip_lg2_i,
  input logic              blk_req_o,
  input logic [CHIP_W-1:0] blk_chip_o,
  input logic [ADDR_W-1:0] blk_addr_o,
  input logic [ADDR_W-1:0] blk_size_o,
  input logic              blk_done_i,
  input logic [STAT_W-1:0] blk_status_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              bad_align_o,
  input logic [STAT_W-1:0] fail_code_o
);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req_o && !blk_done_i |=> blk_req_o && $stable(blk_chip_o) && $stable(blk_addr_o) && $stable(blk_size_o));

  a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req_o |-> (blk_addr_o & (blk_size_o - ADDR_W'(1))) == '0);

  a_r4_in_chip: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req_o |-> (blk_addr_o >> chip_lg2_i) == '0);

  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req_o && blk_done_i && blk_status_i != '0 |=> done_o && fail_code_o == $past(blk_status_i));

  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && len_i == '0 |=> done_o && !bad_align_o && fail_code_o == '0 && !busy_o);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !blk_req_o);

  a_r2_bad_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && bad_align_o |-> fail_code_o == '0);

  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !blk_req_o |=> busy_o || done_o);

endmodule

bind erase_walker erase_walker_chk #(
  .ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .STAT_W(STAT_W), .SH_W(SH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .chip_lg2_i(chip_lg2_i),
  .blk_req_o(blk_req_o), .blk_chip_o(blk_chip_o), .blk_addr_o(blk_addr_o),
  .blk_size_o(blk_size_o), .blk_done_i(blk_done_i), .blk_status_i(blk_status_i),
  .busy_o(busy_o), .done_o(done_o), .bad_align_o(bad_align_o), .fail_code_o(fail_code_o)
);

// File: tb/erase_walker_tb_top.sv
module erase_walker_tb_top;
  localparam int AW = 24, NR = 4, CW = 4, STW = 8;
  localparam int SW = $clog2(AW), IW = $clog2(NR + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, blk_done = 1'b0;
  logic [AW-1:0] ofs = '0, len = '0;
  logic [NR*AW-1:0] rbase, rcnt;
  logic [NR*SW-1:0] rlg2;
  logic [IW-1:0] rnum;
  logic [SW-1:0] clg2;
  logic [CW:0] cnum;
  logic [STW-1:0] blk_status = '0;
  logic blk_req, busy, done, bad;
  logic [CW-1:0] bchip;
  logic [AW-1:0] baddr, bsize;
  logic [STW-1:0] fcode;

  always #4 clk = ~clk;

  erase_walker #(.ADDR_W(AW), .NREG(NR), .CHIP_W(CW), .STAT_W(STW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ofs_i(ofs), .len_i(len),
    .rgn_base_i(rbase), .rgn_lg2_i(rlg2), .rgn_cnt_i(rcnt), .rgn_num_i(rnum),
    .chip_lg2_i(clg2), .chip_num_i(cnum), .blk_req_o(blk_req), .blk_chip_o(bchip),
    .blk_addr_o(baddr), .blk_size_o(bsize), .blk_done_i(blk_done), .blk_status_i(blk_status),
    .busy_o(busy), .done_o(done), .bad_align_o(bad), .fail_code_o(fcode));

  int checks = 0, errors = 0, cyc = 0;
  int t_base [NR], t_lg2 [NR], t_cnt [NR];
  int t_num, t_cs, t_nch;
  int e_chip [64], e_addr [64], e_size [64];
  int e_n, e_bad, e_code;
  int abort_at, abort_val, seen;
  logic hold_chk;
  logic [CW-1:0] h_chip;
  logic [AW-1:0] h_addr, h_size;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_table();
    for (int k = 0; k < NR; k++) begin
      rbase[k*AW +: AW] = AW'(t_base[k]);
      rcnt[k*AW +: AW]  = AW'(t_cnt[k]);
      rlg2[k*SW +: SW]  = SW'(t_lg2[k]);
    end
    rnum = IW'(t_num);
    clg2 = SW'(t_cs);
    cnum = (CW+1)'(t_nch);
  endtask

  task automatic std_table(input int nch);
    t_base[0] = 'h00000; t_lg2[0] = 13; t_cnt[0] = 8;
    t_base[1] = 'h10000; t_lg2[1] = 16; t_cnt[1] = 7;
    t_base[2] = 'h80000; t_lg2[2] = 15; t_cnt[2] = 4;
    t_base[3] = 'hA0000; t_lg2[3] = 16; t_cnt[3] = 6;
    t_num = 4; t_cs = 19; t_nch = nch;
    load_table();
  endtask

  task automatic model(input int o, input int l);
    int i, first, e, chip, addr, sz;
    e_n = 0; e_bad = 0; e_code = 0;
    if (l == 0) return;
    i = 0;
    while (i < t_num && o >= t_base[i]) i++;
    if (i == 0) begin e_bad = 1; return; end
    i--;
    if ((o & ((1 << t_lg2[i]) - 1)) != 0) begin e_bad = 1; return; end
    first = i;
    e = o + l;
    while (i < t_num && e >= t_base[i]) i++;
    i--;
    if ((e & ((1 << t_lg2[i]) - 1)) != 0) begin e_bad = 1; return; end
    chip = o >> t_cs;
    addr = o - (chip << t_cs);
    i = first;
    while (l != 0 && e_n < 64) begin
      sz = 1 << t_lg2[i];
      e_chip[e_n] = chip; e_addr[e_n] = addr; e_size[e_n] = sz;
      e_n++;
      if (e_n - 1 == abort_at) begin e_code = abort_val; return; end
      addr += sz; o += sz; l -= sz;
      if (o == t_base[i] + (t_cnt[i] << t_lg2[i]) && i < t_num - 1) i++;
      if ((addr >> t_cs) != 0) begin
        addr = 0; chip++;
        if (chip >= t_nch) return;
      end
    end
  endtask

  initial begin : handler
    int wait_n;
    hold_chk = 1'b0;
    wait_n = 0;
    forever begin
      @(negedge clk);
      blk_done = 1'b0;
      blk_status = '0;
      if (blk_req) begin
        if (!hold_chk) begin
          if (seen < e_n)
            chk(bchip == CW'(e_chip[seen]) && baddr == AW'(e_addr[seen]) && bsize == AW'(e_size[seen]),
                "R4 R5 R7 R8 request order", {bchip, baddr}, {e_chip[seen][CW-1:0], e_addr[seen][AW-1:0]});
          else
            chk(1'b0, "R5 R8 R10 extra request", int'(baddr), -1);
          hold_chk = 1'b1;
          h_chip = bchip; h_addr = baddr; h_size = bsize;
          seen++;
          wait_n = int'($urandom % 3);
        end else if (bchip != h_chip || baddr != h_addr || bsize != h_size) begin
          chk(1'b0, "R5 request held", int'(baddr), int'(h_addr));
        end
        if (wait_n == 0) begin
          blk_done = 1'b1;
          blk_status = (seen - 1 == abort_at) ? STW'(abort_val) : '0;
          hold_chk = 1'b0;
        end else wait_n--;
      end
    end
  end

  task automatic run_case(input int o, input int l, input int ab, input bit restart, input string tag);
    int t;
    abort_at = ab;
    abort_val = (ab >= 0) ? 'h5A : 0;
    model(o, l);
    seen = 0;
    @(negedge clk);
    ofs = AW'(o); len = AW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 3000) begin
      if (restart && t == 8) begin
        ofs = AW'('h2000); len = AW'('h2000); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    chk(done == 1'b1, {tag, " done seen"}, int'(done), 1);
    chk(bad == 1'(e_bad), {tag, " alignment flag"}, int'(bad), e_bad);
    chk(fcode == STW'(e_code), {tag, " status"}, int'(fcode), e_code);
    chk(seen == e_n, {tag, " request count"}, seen, e_n);
    @(negedge clk);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    std_table(2);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !blk_req && !bad && fcode == 0, "reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: zero length, done in the cycle after start
    abort_at = -1; e_n = 0; seen = 0;
    ofs = AW'('h1000); len = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !bad && fcode == 0 && !busy, "R9 zero length done", int'(done), 1);
    repeat (3) @(negedge clk);
    chk(seen == 0, "R9 no request", seen, 0);

    run_case('h0C000, 'h14000, -1, 1'b0, "R7 R10 boot into big blocks");
    run_case('h70000, 'h30000, -1, 1'b0, "R7 R8 chip crossing into 32K");
    run_case('h02000, 'h04000, -1, 1'b0, "R4 R10 small blocks");
    run_case('h03000, 'h02000, -1, 1'b0, "R2 start misaligned");
    run_case('h20000, 'h08000, -1, 1'b0, "R3 end misaligned");
    run_case('h0E000, 'h0A000, -1, 1'b0, "R3 end misaligned big region");
    run_case('hA0000, 'h60000, -1, 1'b0, "R4 R10 last region to top");
    run_case('h00000, 'h20000, 3, 1'b0, "R6 abort midway");
    run_case('h00000, 'h40000, 2, 1'b1, "R11 start while busy");

    std_table(1);
    run_case('h70000, 'h30000, -1, 1'b0, "R8 chip limit stops walk");

    std_table(2);
    t_base[0] = 'h4000;
    load_table();
    run_case('h02000, 'h02000, -1, 1'b0, "R1 below first region");
    run_case('h04000, 'h04000, -1, 1'b0, "R1 shifted table start");

    std_table(2);
    for (int n = 0; n < 60; n++) begin
      int o, l, ab;
      if ((n % 10) == 9) std_table(1 + int'($urandom % 2));
      o = int'($urandom % 128) * 'h2000;
      l = (1 + int'($urandom % 24)) * 'h2000;
      if (o + l > 'h100000) l = 'h100000 - o;
      ab = (($urandom % 6) == 0) ? int'($urandom % 4) : -1;
      run_case(o, l, ab, 1'b0, "R1 R2 R3 R5 R6 R7 R8 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule